// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block decides when an access on a processor's external memory bus may finish. A wait-state counter is loaded at the start of every external access and counts down once per clock. An external ready input is sampled on each rising clock edge. A two-bit combine select decides how the two are merged: ready only, counter only, both, or either. The select and the count come from a small control register. That register resets to the "either" combination with the largest wait count.

Writes are posted. When the core issues a write, the block latches the address and data and drives them on the bus until the write completes. The core is not stalled for that write. The buffer holds one write. A new request that arrives while a posted write is still on the bus stalls the core until the bus is idle again.

Reads stall the core for the whole bus access. The read data is captured on the edge that completes the access and is presented to the core, with a one-cycle done pulse, on the next cycle.

The sequencer has three states:
- `ST_IDLE`: no bus activity.
- `ST_READ`: a read is on the bus.
- `ST_WRITE`: a posted write is on the bus.

It has four transitions:
- IDLE→READ: a read request is accepted.
- IDLE→WRITE: a write request is accepted.
- READ→IDLE: the combined completion condition is met.
- WRITE→IDLE: the combined completion condition is met.

Top module: `ext_bus_wait_ctrl`

## Requirements
- R1: After reset the bus strobe, core stall and read-done outputs are 0, and the control register holds select 11 with wait count 7.
- R2: With select 00 the counter is ignored. An access ends on the first bus cycle, from the second on, in which ready is high.
- R3: With select 01 ready is ignored. An access loaded with wait count W lasts exactly W+1 bus cycles, and a count of 0 ends it in its first bus cycle.
- R4: With select 10 an access ends only in a bus cycle where the counter has reached zero and ready is honoured high.
- R5: With select 11 an access ends in the first bus cycle where the counter has reached zero or ready is honoured high.
- R6: Ready is not honoured in the first bus cycle of an access, whatever the select.
- R7: An accepted write does not stall the core. During the write, the bus shows R/W = 0 with the latched address and data until completion.
- R8: A request made while a posted write is on the bus is stalled until the first idle cycle after that write, and is accepted there.
- R9: During a read the core stall is high. The bus data of the completing cycle appears on core_rdata, with core_rdone high for one cycle, in the cycle after completion.
- R10: The strobe, R/W (1 = read) and address are stable for the whole access, and the strobe is low in the cycle after completion.
- R11: Select and wait count are taken from the control register when an access is accepted. A register write during an access changes only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| core_req | input | 1 | Core requests an external access this cycle |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | AW | Access address |
| core_wdata | input | DW | Write data |
| core_stall | output | 1 | Request not taken, or read in progress |
| core_rdata | output | DW | Captured read data |
| core_rdone | output | 1 | One-cycle pulse: core_rdata valid |
| ctl_we | input | 1 | Write strobe of the control register |
| ctl_sel | input | 2 | Combine select: 00 ready, 01 counter, 10 both, 11 either |
| ctl_wait | input | WCW | Wait count to load |
| bus_strobe | output | 1 | External access active |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_addr | output | AW | Latched address |
| bus_wdata | output | DW | Latched write data |
| bus_rdata | input | DW | Read data from the bus |
| bus_ready | input | 1 | External ready |

## Verification
A posted write can complete in the same cycle that the core raises a new request. In that cycle the request must still be stalled, and it must be accepted only in the idle cycle that follows. The bench holds a read request from the cycle after a write is issued. It compares the stall, strobe and R/W against its model on every cycle, and it counts the stalled cycles against the write length. A control-register write can also coincide with a running access. That case is provoked mid-access, and the access length is compared with the length set by the earlier configuration.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
    typedef enum logic [1:0] {
        SEL_EXT = 2'b00,
        SEL_INT = 2'b01,
        SEL_AND = 2'b10,
        SEL_OR  = 2'b11
    } wsel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_WRITE = 2'b10
    } bus_st_e;
endpackage

// File: rtl/ebw_ctl_reg.sv
module ebw_ctl_reg
    import ebw_pkg::*;
#(
    parameter int WCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  wsel_e          sel_in,
    input  logic [WCW-1:0] wait_in,
    output wsel_e          sel_o,
    output logic [WCW-1:0] wait_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_o  <= SEL_OR;
            wait_o <= '1;
        end else if (we) begin
            sel_o  <= sel_in;
            wait_o <= wait_in;
        end
    end
endmodule

// File: rtl/ebw_wait_timer.sv
module ebw_wait_timer
    import ebw_pkg::*;
#(
    parameter int WCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [WCW-1:0] load_val,
    input  wsel_e          sel_load,
    input  logic           active,
    input  logic           ready_in,
    output logic           done_o,
    output logic           first_o,
    output logic [1:0]     sel_q_o
);
    logic [WCW-1:0] cnt_q;
    logic           first_q;
    wsel_e          sel_q;
    logic           expired;
    logic           rdy_ok;
    logic           comb_ok;

    assign expired = (cnt_q == '0);
    assign rdy_ok  = ready_in && !first_q;

    always_comb begin
        unique case (sel_q)
            SEL_EXT: comb_ok = rdy_ok;
            SEL_INT: comb_ok = expired;
            SEL_AND: comb_ok = expired && rdy_ok;
            SEL_OR:  comb_ok = expired || rdy_ok;
            default: comb_ok = 1'b0;
        endcase
    end

    assign done_o  = active && comb_ok;
    assign first_o = first_q;
    assign sel_q_o = sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            first_q <= 1'b0;
            sel_q   <= SEL_OR;
        end else if (start) begin
            cnt_q   <= load_val;
            first_q <= 1'b1;
            sel_q   <= sel_load;
        end else if (active && !comb_ok) begin
            if (!expired) begin
                cnt_q <= cnt_q - 1'b1;
            end
            first_q <= 1'b0;
        end
    end
endmodule

// File: rtl/ebw_seq.sv
module ebw_seq
    import ebw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_req,
    input  logic core_we,
    input  logic acc_done,
    output logic start,
    output logic start_wr,
    output logic core_stall,
    output logic bus_strobe,
    output logic bus_rw,
    output logic capture
);
    bus_st_e state_q;
    bus_st_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (core_req) begin
                    state_d = core_we ? ST_WRITE : ST_READ;
                end
            end
            ST_READ, ST_WRITE: begin
                if (acc_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        start      = 1'b0;
        start_wr   = 1'b0;
        core_stall = 1'b0;
        bus_strobe = 1'b0;
        bus_rw     = 1'b0;
        capture    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start    = core_req;
                start_wr = core_req && core_we;
            end
            ST_READ: begin
                core_stall = 1'b1;
                bus_strobe = 1'b1;
                bus_rw     = 1'b1;
                capture    = acc_done;
            end
            ST_WRITE: begin
                core_stall = core_req;
                bus_strobe = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ext_bus_wait_ctrl.sv
module ext_bus_wait_ctrl
    import ebw_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int WCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           core_req,
    input  logic           core_we,
    input  logic [AW-1:0]  core_addr,
    input  logic [DW-1:0]  core_wdata,
    output logic           core_stall,
    output logic [DW-1:0]  core_rdata,
    output logic           core_rdone,
    input  logic           ctl_we,
    input  logic [1:0]     ctl_sel,
    input  logic [WCW-1:0] ctl_wait,
    output logic           bus_strobe,
    output logic           bus_rw,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic [DW-1:0]  bus_rdata,
    input  logic           bus_ready
);
    wsel_e          cfg_sel;
    logic [WCW-1:0] cfg_wait;
    logic           start;
    logic           start_wr;
    logic           capture;
    logic           acc_done;
    logic           tmr_first;
    logic [1:0]     sel_q;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q;
    logic [DW-1:0]  rdata_q;
    logic           rdone_q;

    ebw_ctl_reg #(.WCW(WCW)) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ctl_we),
        .sel_in  (wsel_e'(ctl_sel)),
        .wait_in (ctl_wait),
        .sel_o   (cfg_sel),
        .wait_o  (cfg_wait)
    );

    ebw_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_req   (core_req),
        .core_we    (core_we),
        .acc_done   (acc_done),
        .start      (start),
        .start_wr   (start_wr),
        .core_stall (core_stall),
        .bus_strobe (bus_strobe),
        .bus_rw     (bus_rw),
        .capture    (capture)
    );

    ebw_wait_timer #(.WCW(WCW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load_val (cfg_wait),
        .sel_load (cfg_sel),
        .active   (bus_strobe),
        .ready_in (bus_ready),
        .done_o   (acc_done),
        .first_o  (tmr_first),
        .sel_q_o  (sel_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            rdone_q <= 1'b0;
        end else begin
            if (start) begin
                addr_q <= core_addr;
            end
            if (start_wr) begin
                wdata_q <= core_wdata;
            end
            if (capture) begin
                rdata_q <= bus_rdata;
            end
            rdone_q <= capture;
        end
    end

    assign bus_addr   = addr_q;
    assign bus_wdata  = wdata_q;
    assign core_rdata = rdata_q;
    assign core_rdone = rdone_q;
endmodule

// File: rtl/ebw_checker.sv
module ebw_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_req,
    input logic          core_we,
    input logic          core_stall,
    input logic          core_rdone,
    input logic          bus_strobe,
    input logic          bus_rw,
    input logic [AW-1:0] bus_addr,
    input logic          acc_done,
    input logic          tmr_first,
    input logic [1:0]    sel_q
);
    // R10: access signals held while not finished
    p_strobe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && !acc_done) |=> (bus_strobe && $stable(bus_rw) && $stable(bus_addr)));

    p_strobe_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !bus_strobe);

    p_post_nostall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_strobe && core_req && core_we) |-> !core_stall);

    p_pending_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && !bus_rw && core_req) |-> core_stall);

    p_read_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_rw) |-> core_stall);

    p_rdone_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        core_rdone |-> $past(acc_done && bus_rw));

    p_first_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && tmr_first && sel_q == 2'b00) |-> !acc_done);
endmodule

bind ext_bus_wait_ctrl ebw_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_req   (core_req),
    .core_we    (core_we),
    .core_stall (core_stall),
    .core_rdone (core_rdone),
    .bus_strobe (bus_strobe),
    .bus_rw     (bus_rw),
    .bus_addr   (bus_addr),
    .acc_done   (acc_done),
    .tmr_first  (tmr_first),
    .sel_q      (sel_q)
);

// File: tb/sim_ext_bus_wait_ctrl.sv
`timescale 1ns/1ps
module sim_ext_bus_wait_ctrl;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int WCW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_req = 1'b0, core_we = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic core_stall, core_rdone;
    logic [DW-1:0] core_rdata;
    logic ctl_we = 1'b0;
    logic [1:0] ctl_sel = 2'b00;
    logic [WCW-1:0] ctl_wait = '0;
    logic bus_strobe, bus_rw;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic bus_ready = 1'b0;

    int n_chk = 0, n_fail = 0, ncyc = 0;
    bit s_stall;

    // behavioural model
    int m_busy = 0;      // 0 idle, 1 read, 2 write
    int m_cnt = 0, m_sel = 3, m_wait = 7, m_csel = 3, m_cwait = 7;
    bit m_first = 0, m_rdone = 0;
    int m_addr = 0, m_wdata = 0, m_rdata = 0;

    always #2 clk = ~clk;

    ext_bus_wait_ctrl #(.AW(AW), .DW(DW), .WCW(WCW)) u0 (.*);

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cmp_all();
        check("R10 strobe", int'(bus_strobe), int'(m_busy != 0));
        if (m_busy != 0) begin
            check("R10 rw", int'(bus_rw), int'(m_busy == 1));
            check("R7 addr", int'(bus_addr), m_addr);
        end
        if (m_busy == 2) check("R7 wdata", int'(bus_wdata), m_wdata);
        check(m_busy == 2 ? "R8 stall" : "R9 stall", int'(core_stall),
              int'(m_busy == 1 || (m_busy == 2 && core_req)));
        check("R9 rdone", int'(core_rdone), int'(m_rdone));
        if (m_rdone) check("R9 rdata", int'(core_rdata), m_rdata);
    endtask

    task automatic model_step();
        bit rdy, ex, dn;
        m_rdone = 0;
        if (m_busy == 0) begin
            if (core_req) begin
                m_busy = core_we ? 2 : 1;
                m_cnt = m_cwait; m_sel = m_csel; m_first = 1;
                m_addr = int'(core_addr);
                if (core_we) m_wdata = int'(core_wdata);
            end
        end else begin
            rdy = bus_ready && !m_first;
            ex = (m_cnt == 0);
            case (m_sel)
                0: dn = rdy;
                1: dn = ex;
                2: dn = ex && rdy;
                default: dn = ex || rdy;
            endcase
            if (dn) begin
                if (m_busy == 1) begin m_rdone = 1; m_rdata = int'(bus_rdata); end
                m_busy = 0;
            end else begin
                if (m_cnt > 0) m_cnt--;
                m_first = 0;
            end
        end
        if (ctl_we) begin m_csel = int'(ctl_sel); m_cwait = int'(ctl_wait); end
    endtask

    // one clock: inputs already set at the negedge
    task automatic cyc();
        bus_rdata = 16'hA000 + 16'(ncyc * 7);
        #1;
        cmp_all();
        s_stall = core_stall;
        @(posedge clk);
        if (rst_n) model_step();
        ncyc++;
        @(negedge clk);
    endtask

    task automatic setcfg(input logic [1:0] s, input logic [2:0] w);
        ctl_we = 1; ctl_sel = s; ctl_wait = w; cyc(); ctl_we = 0;
    endtask

    task automatic access(input bit we, input logic [15:0] a, input logic [15:0] d,
                          input int rfrom, input int exp_len, input bit cfgw,
                          input logic [1:0] cs, input logic [2:0] cw, input string tag);
        int idx = 0;
        core_req = 1; core_we = we; core_addr = a; core_wdata = d; bus_ready = 0;
        cyc();
        if (we) check("R7 write issue no stall", int'(s_stall), 0);
        core_req = 0;
        for (int k = 0; k < 40; k++) begin
            if (!bus_strobe) break;
            idx++;
            bus_ready = (rfrom != 0 && idx >= rfrom);
            ctl_we = cfgw && (idx == 2); ctl_sel = cs; ctl_wait = cw;
            cyc();
            ctl_we = 0;
        end
        check(tag, idx, exp_len);
        bus_ready = 0;
        cyc();
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int nst = 0;
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc();
        check("R1 reset strobe", int'(bus_strobe), 0);
        check("R1 reset stall", int'(core_stall), 0);
        check("R1 reset rdone", int'(core_rdone), 0);
        rst_n = 1;
        cyc();
        // R1 R5 defaults: select 11, wait 7
        access(0, 16'h0100, 0, 0, 8, 0, 0, 0, "R1 default wait 7 length");
        access(0, 16'h0104, 0, 1, 2, 0, 0, 0, "R5 R6 default OR ready");
        // R2
        setcfg(2'b00, 3'd7);
        access(0, 16'h0200, 0, 1, 2, 0, 0, 0, "R2 R6 ready-only early");
        access(1, 16'h0204, 16'h5A5A, 4, 4, 0, 0, 0, "R2 ready-only late");
        // R3
        setcfg(2'b01, 3'd3);
        access(0, 16'h0300, 0, 1, 4, 0, 0, 0, "R3 counter-only wait 3");
        setcfg(2'b01, 3'd0);
        access(1, 16'h0304, 16'h1234, 0, 1, 0, 0, 0, "R3 counter-only wait 0");
        // R4
        setcfg(2'b10, 3'd1);
        access(0, 16'h0400, 0, 5, 5, 0, 0, 0, "R4 AND waits ready");
        setcfg(2'b10, 3'd6);
        access(0, 16'h0404, 0, 1, 7, 0, 0, 0, "R4 AND waits counter");
        // R5 counter zero
        setcfg(2'b11, 3'd0);
        access(0, 16'h0500, 0, 0, 1, 0, 0, 0, "R5 OR expired at once");
        // R11 config written mid-access
        setcfg(2'b01, 3'd3);
        access(0, 16'h0600, 0, 0, 4, 1, 2'b01, 3'd0, "R11 running access keeps config");
        access(0, 16'h0604, 0, 0, 1, 0, 0, 0, "R11 next access uses new config");
        // R8: request during posted write
        setcfg(2'b01, 3'd4);
        core_req = 1; core_we = 1; core_addr = 16'h0700; core_wdata = 16'hBEEF;
        cyc();
        check("R7 posted write not stalled", int'(s_stall), 0);
        core_we = 0; core_addr = 16'h0708;
        for (int k = 0; k < 40; k++) begin
            if (!bus_strobe) break;
            cyc();
            nst += int'(s_stall);
        end
        check("R8 stall cycles during write", nst, 5);
        cyc();
        check("R8 accepted in idle cycle", int'(s_stall), 0);
        core_req = 0;
        for (int k = 0; k < 40; k++) begin
            if (!bus_strobe) break;
            cyc();
        end
        check("R9 read after write done pulse", int'(core_rdone), 1);
        cyc();
        cyc();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule